// File: doc/BRIEF.md
# Port Reset and Link-Up Sequencer

This block sits beside each root port of a serial-link host controller and owns the active-low reset lines that go to the physical layer, the PIPE interface, the MAC, the configuration space and the endpoint's fundamental reset. Software drives these lines through a per-port reset control register. A shared enable register, common to all ports, holds one training-enable bit and one low-power-L1-enable bit per slot, packed at an 8-bit stride.

Link training is modelled by a `train_done` input per port. The block reports link-up only while training is allowed. If link-up does not arrive within a programmable window after training becomes possible, the block raises a sticky timeout flag. When the link-down auto-reset field is set and an established link drops, the block pulses the MAC and configuration resets by itself for a fixed number of cycles. The register contents are left as software wrote them.

The intended bring-up order is as follows. Enable training for the slot, write zero to the reset register, set the auto-reset field, release the five resets, and then poll the status register for link-up or timeout.

Top module: `port_reset_sequencer`

## Requirements
- R1: After reset every reset output is 0 (asserted), every enable output and link_up are 0, and the shared, reset-control and status registers read 0.
- R2: The shared register (offset 0x000) stores, for slot n, the training enable at bit 8n and the L1 enable at bit 8n+1; it drives ltssm_en[n] and aspm_l1_en[n]; all other bits read 0.
- R3: The reset control register (offset 0x510, port chosen by reg_port) keeps bit 0 (PHY), bit 1 (PIPE), bit 2 (MAC), bit 3 (config), bit 8 (PERST) and bits 15:13 (auto-reset enable); other bits read 0; each kept reset bit drives its active-low output from the cycle after the write.
- R4: Training is allowed only when ltssm_en and the PHY, PIPE, MAC and PERST resets are all released; the config reset does not gate training.
- R5: The status register (offset 0x804) shows link-up at bit 10; link_up is train_done registered once while training is allowed, so it rises one cycle after the write that allows training.
- R6: With any bit of 15:13 set, a link_up fall drives mac_rst_n and cfg_rst_n low for exactly PULSE_CYCLES cycles starting the cycle after the fall, and the register still reads its written value.
- R7: With bits 15:13 clear, a link_up fall leaves mac_rst_n and cfg_rst_n at their register values.
- R8: A timer counts the cycles during which training is allowed and link_up is low; status bit 0 (timeout) sets when TIMEOUT_CYCLES such cycles pass without a break, and does not set if link_up rises in time.
- R9: The timeout flag is sticky through link-up and clears in the cycle after the PHY reset bit reads 0 in the register.
- R10: Each port's reset register, link state and outputs are independent of the other ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_port | input | PORT_W | Port selected for per-port registers |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr/reg_port |
| train_done | input | NUM_PORTS | Training-done level from each port's link trainer |
| phy_rst_n | output | NUM_PORTS | PHY reset, active low |
| pipe_rst_n | output | NUM_PORTS | PIPE reset, active low |
| mac_rst_n | output | NUM_PORTS | MAC reset, active low, includes auto pulse |
| cfg_rst_n | output | NUM_PORTS | Configuration-space reset, active low, includes auto pulse |
| perst_n | output | NUM_PORTS | Endpoint fundamental reset, active low |
| ltssm_en | output | NUM_PORTS | Training enable per slot |
| aspm_l1_en | output | NUM_PORTS | L1 power-state enable per slot |
| link_up | output | NUM_PORTS | Link-up indication per port |

## Verification
The hardest situation to reach from the ports is the exact edge of the training window. One run must keep the link down through the final allowed cycle so that the flag appears on that cycle and not one earlier. A second run must raise the link on the last cycle that still avoids the flag. The stimulus counts cycles from the releasing write and moves train_done on a fixed cycle in each run. The auto-reset pulse needs an established link that then drops while the enable field is set, so the bench first trains the link and then withdraws train_done. It checks the pins on each cycle of the pulse and reads the register back partway through the pulse.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int unsigned REG_W = 32;

  // register byte offsets
  localparam logic [11:0] OFS_SLOT_EN = 12'h000;
  localparam logic [11:0] OFS_RST_CTL = 12'h510;
  localparam logic [11:0] OFS_STATUS  = 12'h804;

  // reset control bit positions
  localparam int unsigned B_PHY    = 0;
  localparam int unsigned B_PIPE   = 1;
  localparam int unsigned B_MAC    = 2;
  localparam int unsigned B_CFG    = 3;
  localparam int unsigned B_PERST  = 8;
  localparam int unsigned B_LDR_LO = 13;
  localparam int unsigned B_LDR_HI = 15;

  // status bit positions
  localparam int unsigned B_TMO  = 0;
  localparam int unsigned B_LINK = 10;

  // per-slot stride in the shared enable register
  localparam int unsigned SLOT_STRIDE = 8;
  localparam int unsigned B_TRAIN_EN  = 0;
  localparam int unsigned B_L1_EN     = 1;

  typedef struct packed {
    logic [2:0] ldr_en;
    logic       perst;
    logic       cfg;
    logic       mac;
    logic       pipe;
    logic       phy;
  } rst_ctl_t;

endpackage

// File: rtl/rsq_slot_en.sv
module rsq_slot_en
  import rsq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_we,
  input  logic [REG_W-1:0]     en_wdata,
  output logic [REG_W-1:0]     en_view,
  output logic [NUM_PORTS-1:0] train_en,
  output logic [NUM_PORTS-1:0] l1_en
);

  logic [NUM_PORTS-1:0] train_q, train_d;
  logic [NUM_PORTS-1:0] l1_q, l1_d;

  always_comb begin
    train_d = train_q;
    l1_d    = l1_q;
    if (en_we) begin
      for (int n = 0; n < NUM_PORTS; n++) begin
        train_d[n] = en_wdata[n*SLOT_STRIDE + B_TRAIN_EN];
        l1_d[n]    = en_wdata[n*SLOT_STRIDE + B_L1_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_q <= '0;
      l1_q    <= '0;
    end else begin
      train_q <= train_d;
      l1_q    <= l1_d;
    end
  end

  always_comb begin
    en_view = '0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      en_view[n*SLOT_STRIDE + B_TRAIN_EN] = train_q[n];
      en_view[n*SLOT_STRIDE + B_L1_EN]    = l1_q[n];
    end
  end

  assign train_en = train_q;
  assign l1_en    = l1_q;

endmodule

// File: rtl/rsq_port_ctrl.sv
module rsq_port_ctrl
  import rsq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 12500000,
  parameter int unsigned PULSE_CYCLES   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             train_en,
  input  logic             train_done,
  output logic [REG_W-1:0] ctl_view,
  output logic [REG_W-1:0] stat_view,
  output logic             phy_rst_n,
  output logic             pipe_rst_n,
  output logic             mac_rst_n,
  output logic             cfg_rst_n,
  output logic             perst_n,
  output logic             link_up,
  output logic             ldr_armed,
  output logic             tmo_flag
);

  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int unsigned PLS_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(PULSE_CYCLES);

  rst_ctl_t         ctl_q, ctl_d;
  logic             link_q, link_d;
  logic [PLS_W-1:0] pls_q, pls_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmo_q, tmo_d;

  logic pulse_on, train_ok, link_fall, tmr_run, tmr_hit;

  // reset control register
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.phy    = ctl_wdata[B_PHY];
      ctl_d.pipe   = ctl_wdata[B_PIPE];
      ctl_d.mac    = ctl_wdata[B_MAC];
      ctl_d.cfg    = ctl_wdata[B_CFG];
      ctl_d.perst  = ctl_wdata[B_PERST];
      ctl_d.ldr_en = ctl_wdata[B_LDR_HI:B_LDR_LO];
    end
  end

  assign pulse_on   = (pls_q != '0);
  assign ldr_armed  = |ctl_q.ldr_en;

  assign phy_rst_n  = ctl_q.phy;
  assign pipe_rst_n = ctl_q.pipe;
  assign mac_rst_n  = ctl_q.mac & ~pulse_on;
  assign cfg_rst_n  = ctl_q.cfg & ~pulse_on;
  assign perst_n    = ctl_q.perst;

  // training gate and link state
  assign train_ok  = train_en & ctl_q.phy & ctl_q.pipe & mac_rst_n & ctl_q.perst;
  assign link_d    = train_ok & train_done;
  assign link_fall = link_q & ~link_d;

  // link-down auto-reset pulse
  always_comb begin
    pls_d = pls_q;
    if (link_fall && ldr_armed) begin
      pls_d = PLS_LOAD;
    end else if (pulse_on) begin
      pls_d = pls_q - 1'b1;
    end
  end

  // training window timer and sticky flag
  assign tmr_run = train_ok & ~link_q & ~tmo_q;
  assign tmr_hit = tmr_run && (tmr_q == TMR_LAST);

  always_comb begin
    tmr_d = tmr_run ? tmr_q + 1'b1 : '0;
    tmo_d = tmo_q;
    if (!ctl_q.phy) begin
      tmo_d = 1'b0;
    end else if (tmr_hit) begin
      tmo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      link_q <= 1'b0;
      pls_q  <= '0;
      tmr_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      link_q <= link_d;
      pls_q  <= pls_d;
      tmr_q  <= tmr_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    ctl_view                    = '0;
    ctl_view[B_PHY]             = ctl_q.phy;
    ctl_view[B_PIPE]            = ctl_q.pipe;
    ctl_view[B_MAC]             = ctl_q.mac;
    ctl_view[B_CFG]             = ctl_q.cfg;
    ctl_view[B_PERST]           = ctl_q.perst;
    ctl_view[B_LDR_HI:B_LDR_LO] = ctl_q.ldr_en;
    stat_view                   = '0;
    stat_view[B_LINK]           = link_q;
    stat_view[B_TMO]            = tmo_q;
  end

  assign link_up  = link_q;
  assign tmo_flag = tmo_q;

endmodule

// File: rtl/port_reset_sequencer.sv
module port_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int unsigned NUM_PORTS      = 2,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned TIMEOUT_CYCLES = 12500000,
  parameter int unsigned PULSE_CYCLES   = 16,
  localparam int unsigned PORT_W        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [PORT_W-1:0]    reg_port,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_PORTS-1:0] train_done,
  output logic [NUM_PORTS-1:0] phy_rst_n,
  output logic [NUM_PORTS-1:0] pipe_rst_n,
  output logic [NUM_PORTS-1:0] mac_rst_n,
  output logic [NUM_PORTS-1:0] cfg_rst_n,
  output logic [NUM_PORTS-1:0] perst_n,
  output logic [NUM_PORTS-1:0] ltssm_en,
  output logic [NUM_PORTS-1:0] aspm_l1_en,
  output logic [NUM_PORTS-1:0] link_up
);

  localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(OFS_SLOT_EN);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFS_RST_CTL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  logic                 slot_we;
  logic [REG_W-1:0]     slot_view;
  logic [REG_W-1:0]     ctl_view_w  [NUM_PORTS];
  logic [REG_W-1:0]     stat_view_w [NUM_PORTS];
  logic [NUM_PORTS-1:0] ldr_arm_w;
  logic [NUM_PORTS-1:0] tmo_w;

  assign slot_we = reg_we && (reg_addr == A_SLOT);

  rsq_slot_en #(
    .NUM_PORTS (NUM_PORTS)
  ) u_slot_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (slot_we),
    .en_wdata (reg_wdata),
    .en_view  (slot_view),
    .train_en (ltssm_en),
    .l1_en    (aspm_l1_en)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic ctl_we;
    assign ctl_we = reg_we && (reg_addr == A_RST) && (reg_port == PORT_W'(p));

    rsq_port_ctrl #(
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
      .PULSE_CYCLES   (PULSE_CYCLES)
    ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we),
      .ctl_wdata  (reg_wdata),
      .train_en   (ltssm_en[p]),
      .train_done (train_done[p]),
      .ctl_view   (ctl_view_w[p]),
      .stat_view  (stat_view_w[p]),
      .phy_rst_n  (phy_rst_n[p]),
      .pipe_rst_n (pipe_rst_n[p]),
      .mac_rst_n  (mac_rst_n[p]),
      .cfg_rst_n  (cfg_rst_n[p]),
      .perst_n    (perst_n[p]),
      .link_up    (link_up[p]),
      .ldr_armed  (ldr_arm_w[p]),
      .tmo_flag   (tmo_w[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SLOT) begin
      reg_rdata = slot_view;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reg_port == PORT_W'(p)) begin
          if (reg_addr == A_RST)  reg_rdata = ctl_view_w[p];
          if (reg_addr == A_STAT) reg_rdata = stat_view_w[p];
        end
      end
    end
  end

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PORT_W    = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [PORT_W-1:0]    reg_port,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [NUM_PORTS-1:0] train_done,
  input logic [NUM_PORTS-1:0] phy_rst_n,
  input logic [NUM_PORTS-1:0] pipe_rst_n,
  input logic [NUM_PORTS-1:0] mac_rst_n,
  input logic [NUM_PORTS-1:0] cfg_rst_n,
  input logic [NUM_PORTS-1:0] perst_n,
  input logic [NUM_PORTS-1:0] ltssm_en,
  input logic [NUM_PORTS-1:0] link_up,
  input logic [NUM_PORTS-1:0] ldr_arm_w,
  input logic [NUM_PORTS-1:0] tmo_w
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk

    // R4: link only follows a cycle in which training was allowed and done
    a_r4_link_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      link_up[i] |-> $past(ltssm_en[i] && phy_rst_n[i] && pipe_rst_n[i] &&
                           mac_rst_n[i] && perst_n[i] && train_done[i]));

    // R6: an armed link drop pulls MAC and config resets low at once
    a_r6_autorst_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(link_up[i]) && $past(ldr_arm_w[i])) |-> (!mac_rst_n[i] && !cfg_rst_n[i]));

    // R3: a write to this port's control register appears on the pins next cycle
    a_r3_pins_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && reg_addr == ADDR_W'(OFS_RST_CTL) && reg_port == PORT_W'(i))
      |-> (phy_rst_n[i] == $past(reg_wdata[B_PHY]) &&
           pipe_rst_n[i] == $past(reg_wdata[B_PIPE]) &&
           perst_n[i] == $past(reg_wdata[B_PERST])));

    // R9: timeout flag holds while PHY reset stays released
    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_w[i] && phy_rst_n[i]) |=> tmo_w[i]);

    // R2: slot enable bit lands at stride position
    a_r2_slot_bits: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && reg_addr == ADDR_W'(OFS_SLOT_EN))
      |-> (ltssm_en[i] == $past(reg_wdata[i*SLOT_STRIDE + B_TRAIN_EN])));
  end

endmodule

bind port_reset_sequencer rsq_checker #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W),
  .PORT_W    (PORT_W)
) u_rsq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_port   (reg_port),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .train_done (train_done),
  .phy_rst_n  (phy_rst_n),
  .pipe_rst_n (pipe_rst_n),
  .mac_rst_n  (mac_rst_n),
  .cfg_rst_n  (cfg_rst_n),
  .perst_n    (perst_n),
  .ltssm_en   (ltssm_en),
  .link_up    (link_up),
  .ldr_arm_w  (ldr_arm_w),
  .tmo_w      (tmo_w)
);

// File: tb/port_reset_sequencer_tb.sv
module port_reset_sequencer_tb;

  localparam int NP   = 2;
  localparam int TMO  = 20;
  localparam int PLS  = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [0:0]  reg_port;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NP-1:0] train_done;
  logic [NP-1:0] phy_rst_n, pipe_rst_n, mac_rst_n, cfg_rst_n, perst_n;
  logic [NP-1:0] ltssm_en, aspm_l1_en, link_up;

  port_reset_sequencer #(
    .NUM_PORTS      (NP),
    .ADDR_W         (12),
    .TIMEOUT_CYCLES (TMO),
    .PULSE_CYCLES   (PLS)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_port   (reg_port),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .train_done (train_done),
    .phy_rst_n  (phy_rst_n),
    .pipe_rst_n (pipe_rst_n),
    .mac_rst_n  (mac_rst_n),
    .cfg_rst_n  (cfg_rst_n),
    .perst_n    (perst_n),
    .ltssm_en   (ltssm_en),
    .aspm_l1_en (aspm_l1_en),
    .link_up    (link_up)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;   // 0 = read data, 1 = port0 pins, 2 = port1 pins
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    finished = 0;

  localparam logic [11:0] A_SLOT = 12'h000;
  localparam logic [11:0] A_RST  = 12'h510;
  localparam logic [11:0] A_STAT = 12'h804;

  // pins packed as {link, ltssm, l1, perst, cfg, mac, pipe, phy}
  function automatic logic [31:0] observe(int sel);
    int p;
    if (sel == 0) return reg_rdata;
    p = sel - 1;
    return {24'h0, link_up[p], ltssm_en[p], aspm_l1_en[p], perst_n[p],
            cfg_rst_n[p], mac_rst_n[p], pipe_rst_n[p], phy_rst_n[p]};
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_vec++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(string req, int sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(int port, logic [11:0] addr, logic [31:0] data);
    reg_we    = 1'b1;
    reg_port  = 1'(port);
    reg_addr  = addr;
    reg_wdata = data;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic rd(string req, int port, logic [11:0] addr, logic [31:0] exp);
    reg_port = 1'(port);
    reg_addr = addr;
    expect_item(req, 0, exp);
    tick();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_port = '0; reg_addr = '0; reg_wdata = '0;
    train_done = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_item("R1", 1, 32'h00);
    expect_item("R1", 2, 32'h00);
    rd("R1", 0, A_RST,  32'h0);
    rd("R1", 0, A_SLOT, 32'h0);
    rd("R1", 0, A_STAT, 32'h0);

    // R2 shared register layout
    wr(0, A_SLOT, 32'hFFFF_FFFF);
    expect_item("R2", 1, 32'h60);
    rd("R2", 0, A_SLOT, 32'h0000_0303);
    wr(0, A_SLOT, 32'h0000_0100);
    expect_item("R2", 1, 32'h00);
    expect_item("R2", 2, 32'h40);

    // R3 reset register mask and pins
    wr(0, A_RST, 32'hFFFF_FFFF);
    expect_item("R3", 1, 32'h1F);
    expect_item("R10", 2, 32'h40);
    rd("R3", 0, A_RST, 32'h0000_E10F);

    // R4 training disabled for slot 0
    train_done[0] = 1'b1;
    tick(); tick();
    expect_item("R4", 1, 32'h1F);

    // R4 PHY reset held blocks training
    wr(0, A_RST, 32'h0000_E10E);
    wr(0, A_SLOT, 32'h0000_0101);
    tick(); tick();
    expect_item("R4", 1, 32'h5E);

    // R5 link-up latency
    wr(0, A_RST, 32'h0000_E10F);
    expect_item("R5", 1, 32'h5F);
    tick();
    expect_item("R5", 1, 32'hDF);
    rd("R5", 0, A_STAT, 32'h0000_0400);

    // R6 link-down auto-reset pulse
    train_done[0] = 1'b0;
    expect_item("R6", 1, 32'hDF);
    tick();
    expect_item("R6", 1, 32'h53);
    rd("R6", 0, A_RST, 32'h0000_E10F);
    expect_item("R6", 1, 32'h53);
    tick();
    expect_item("R6", 1, 32'h53);
    tick();
    expect_item("R6", 1, 32'h53);
    tick();
    expect_item("R6", 1, 32'h5F);

    // R4 config reset does not gate; R7 no auto-reset when field clear
    wr(0, A_RST, 32'h0);
    train_done[0] = 1'b1;
    wr(0, A_RST, 32'h0000_0107);
    tick();
    expect_item("R4", 1, 32'hD7);
    train_done[0] = 1'b0;
    tick();
    expect_item("R7", 1, 32'h57);
    tick();
    expect_item("R7", 1, 32'h57);

    // R8 timeout boundary: never trains
    wr(0, A_RST, 32'h0);
    wr(0, A_RST, 32'h0000_0107);
    repeat (TMO - 1) tick();
    rd("R8", 0, A_STAT, 32'h0);
    rd("R8", 0, A_STAT, 32'h1);

    // R9 sticky through link-up, clears after PHY reset asserted
    train_done[0] = 1'b1;
    tick(); tick();
    rd("R9", 0, A_STAT, 32'h0000_0401);
    wr(0, A_RST, 32'h0);
    tick();
    rd("R9", 0, A_STAT, 32'h0);

    // R8 link arrives on the last cycle before timeout
    train_done[0] = 1'b0;
    wr(0, A_RST, 32'h0000_0107);
    repeat (TMO - 2) tick();
    train_done[0] = 1'b1;
    repeat (4) tick();
    rd("R8", 0, A_STAT, 32'h0000_0400);

    // R10 port independence
    train_done[1] = 1'b1;
    wr(1, A_RST, 32'h0000_0107);
    tick();
    expect_item("R10", 2, 32'hD7);
    rd("R10", 1, A_STAT, 32'h0000_0400);
    rd("R10", 1, A_RST,  32'h0000_0107);
    rd("R10", 0, A_RST,  32'h0000_0107);
    expect_item("R10", 1, 32'hD7);
    tick();

    finished = 1;
    finish_run();
  end

endmodule